// File: doc/BRIEF.md
# Privilege-gated bus address decoder

This block sits between a 32-bit CPU data port and the memories and peripheral cores of a small secure SoC. It splits each address into a region (ROM, RAM, reserved, memory-mapped I/O) and, for I/O, into a 6-bit core index and an in-core offset. It then raises a select strobe for the target and routes that target's read data back to the CPU. Every access completes in the cycle it is presented.

The block also owns a one-way privilege flag. After reset the device runs in boot mode, where every register is reachable. Any write to the local switch register moves the device into app mode. Only a reset brings it back. In app mode, the secret-holding core, the boot-only scratch RAM and the authentication-key words disappear from the map. The words that hold the application location, its size and its derived identity become read-only.

A blocked access never raises a bus error. It completes normally, returns zero and selects nothing, so the blocked target sees no access at all.

Top module: `bus_priv_decoder`

## Requirements
- R1: Address bits [31:30] choose the region. 00 raises `rom_sel` and 01 raises `ram_sel`. At most one of `rom_sel`, `ram_sel` and the `core_sel` bits is high in any cycle.
- R2: In region 11, bits [29:24] choose the core. The top byte maps to these `core_sel` bits: 0xc0 to bit 0 (entropy), 0xc1 to bit 1 (timer), 0xc2 to bit 2 (device secret), 0xc3 to bit 3 (serial), 0xc4 to bit 4 (touch), 0xd0 to bit 5 (boot scratch RAM) and 0xff to bit 6 (system control). Any other code selects nothing and reads 0.
- R3: An access to region 10 selects nothing and reads 0.
- R4: `cpu_ready` equals `cpu_valid`, so each access completes in one cycle. With `cpu_valid` low, no select is raised and `dev_wstrb` is 0.
- R5: A write is an access with any `cpu_wstrb` bit set. A write to the switch word (top byte 0xff, in-core offset 0x100) sets `app_mode` at the next clock edge. `app_mode` then stays high until reset. A read of that word, or an access with `cpu_valid` low, leaves the mode unchanged.
- R6: A read of the switch word returns 0x00000000 in boot mode and 0xffffffff in app mode. The switch word is served locally and raises no select.
- R7: In app mode, the device-secret core, the boot scratch RAM, and the authentication-key words (system control offsets 0x300 to 0x30f) are hidden. An access to them raises no select, drives `dev_wstrb` to 0 and reads 0.
- R8: In app mode, a write to the application-location word (0x200), the application-size word (0x204) or the identity words (0x280 to 0x29f) of system control raises no select and drives `dev_wstrb` to 0. Reads of these words still select core 6 and return its data.
- R9: In boot mode every decoded target is reachable for both read and write, and `dev_wstrb` carries `cpu_wstrb`.
- R10: Read data comes from the selected target: `rom_rdata`, `ram_rdata`, or the 32-bit slice i of `core_rdata` for `core_sel` bit i.
- R11: After reset `app_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Access request |
| cpu_addr | input | 32 | Byte address |
| cpu_wstrb | input | 4 | Byte write enables; nonzero means write |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access complete |
| cpu_rdata | output | 32 | Read data |
| rom_sel | output | 1 | ROM select |
| ram_sel | output | 1 | RAM select |
| core_sel | output | 7 | One-hot peripheral core select |
| mem_addr | output | 30 | Address below the region bits |
| dev_wstrb | output | 4 | Gated byte write enables |
| dev_wdata | output | 32 | Write data to targets |
| rom_rdata | input | 32 | ROM read data |
| ram_rdata | input | 32 | RAM read data |
| core_rdata | input | 224 | Core read data, 32 bits per core |
| app_mode | output | 1 | Privilege flag, 1 in app mode |

## Verification
Selects, gated strobes, ready and read data are combinational. They are due in the same cycle as the request, so the bench drives on the falling edge and samples 2 ns later, before the next rising edge. The privilege flag is the only registered result. It is due one rising edge after the switch write, so the bench samples it 1 ns after that edge and compares it with the mode the vector table expects. Mode stickiness and the return to boot mode are checked across a later reset and across accesses that must not change the flag.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int CSEL_W  = 6;
    localparam int OFF_W   = ADDR_W - 2 - CSEL_W;   // in-core byte offset
    localparam int WOFF_W  = OFF_W - 2;             // in-core word offset
    localparam int NCORE   = 7;

    typedef enum logic [1:0] {
        RG_ROM  = 2'b00,
        RG_RAM  = 2'b01,
        RG_RSV  = 2'b10,
        RG_MMIO = 2'b11
    } region_e;

    // core index -> 6-bit core code (address bits [29:24])
    localparam logic [CSEL_W-1:0] CORE_CODE [NCORE] =
        '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h10, 6'h3f};

    localparam int CI_SECRET = 2;
    localparam int CI_SCRAM  = 5;
    localparam int CI_SYS    = 6;

    // system-control byte offsets
    localparam logic [OFF_W-1:0] OFF_SWITCH   = 24'h000100;
    localparam logic [OFF_W-1:0] OFF_APP_LOC  = 24'h000200;
    localparam logic [OFF_W-1:0] OFF_APP_LEN  = 24'h000204;
    localparam logic [OFF_W-1:0] OFF_ID_LO    = 24'h000280;
    localparam logic [OFF_W-1:0] OFF_ID_HI    = 24'h00029c;
    localparam logic [OFF_W-1:0] OFF_AKEY_LO  = 24'h000300;
    localparam logic [OFF_W-1:0] OFF_AKEY_HI  = 24'h00030c;

    typedef struct packed {
        logic app_mode;
    } state_t;
endpackage

// File: rtl/bpd_region_dec.sv
module bpd_region_dec
    import bpd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [NCORE-1:0]  core_hit
);
    assign region = region_e'(addr[ADDR_W-1 -: 2]);

    for (genvar i = 0; i < NCORE; i++) begin : g_hit
        assign core_hit[i] = (region == RG_MMIO) &&
                             (addr[ADDR_W-3 -: CSEL_W] == CORE_CODE[i]);
    end
endmodule

// File: rtl/bpd_perm.sv
module bpd_perm
    import bpd_pkg::*;
(
    input  logic              app_mode,
    input  logic              is_wr,
    input  logic [NCORE-1:0]  core_hit,
    input  logic [WOFF_W-1:0] woff,
    output logic              is_switch,
    output logic              deny
);
    logic sys_hit;
    logic in_akey;
    logic in_ro;
    logic hidden;
    logic ro_block;

    assign sys_hit   = core_hit[CI_SYS];
    assign is_switch = sys_hit && (woff == OFF_SWITCH[OFF_W-1:2]);

    assign in_akey = (woff >= OFF_AKEY_LO[OFF_W-1:2]) &&
                     (woff <= OFF_AKEY_HI[OFF_W-1:2]);
    assign in_ro   = (woff == OFF_APP_LOC[OFF_W-1:2]) ||
                     (woff == OFF_APP_LEN[OFF_W-1:2]) ||
                     ((woff >= OFF_ID_LO[OFF_W-1:2]) &&
                      (woff <= OFF_ID_HI[OFF_W-1:2]));

    assign hidden   = app_mode && (core_hit[CI_SECRET] || core_hit[CI_SCRAM] ||
                                   (sys_hit && in_akey));
    assign ro_block = app_mode && is_wr && sys_hit && in_ro;
    assign deny     = hidden || ro_block;
endmodule

// File: rtl/bus_priv_decoder.sv
module bus_priv_decoder
    import bpd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_valid,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [STRB_W-1:0]       cpu_wstrb,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    rom_sel,
    output logic                    ram_sel,
    output logic [NCORE-1:0]        core_sel,
    output logic [ADDR_W-3:0]       mem_addr,
    output logic [STRB_W-1:0]       dev_wstrb,
    output logic [DATA_W-1:0]       dev_wdata,
    input  logic [DATA_W-1:0]       rom_rdata,
    input  logic [DATA_W-1:0]       ram_rdata,
    input  logic [NCORE*DATA_W-1:0] core_rdata,
    output logic                    app_mode
);
    state_t            s_d, s_q;
    region_e           region;
    logic [NCORE-1:0]  core_hit;
    logic              is_wr;
    logic              is_switch;
    logic              deny;
    logic              grant;
    logic [DATA_W-1:0] core_mux [NCORE+1];

    bpd_region_dec u_region (
        .addr     (cpu_addr),
        .region   (region),
        .core_hit (core_hit)
    );

    bpd_perm u_perm (
        .app_mode  (s_q.app_mode),
        .is_wr     (is_wr),
        .core_hit  (core_hit),
        .woff      (cpu_addr[OFF_W-1:2]),
        .is_switch (is_switch),
        .deny      (deny)
    );

    assign is_wr = |cpu_wstrb;

    // or-reduce the read data of the selected core
    assign core_mux[0] = '0;
    for (genvar i = 0; i < NCORE; i++) begin : g_rmux
        assign core_mux[i+1] = core_mux[i] |
            (core_sel[i] ? core_rdata[i*DATA_W +: DATA_W] : '0);
    end

    always_comb begin
        s_d       = s_q;
        grant     = cpu_valid && !deny && !is_switch;
        rom_sel   = grant && (region == RG_ROM);
        ram_sel   = grant && (region == RG_RAM);
        core_sel  = grant ? core_hit : '0;
        dev_wstrb = (rom_sel || ram_sel || (|core_sel)) ? cpu_wstrb : '0;
        if (cpu_valid && is_wr && is_switch)
            s_d.app_mode = 1'b1;
        if (cpu_valid && is_switch)
            cpu_rdata = {DATA_W{s_q.app_mode}};
        else if (rom_sel)
            cpu_rdata = rom_rdata;
        else if (ram_sel)
            cpu_rdata = ram_rdata;
        else
            cpu_rdata = core_mux[NCORE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_ready = cpu_valid;
    assign mem_addr  = cpu_addr[ADDR_W-3:0];
    assign dev_wdata = cpu_wdata;
    assign app_mode  = s_q.app_mode;
endmodule

// File: rtl/bpd_chk.sv
module bpd_chk
    import bpd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_valid,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic [STRB_W-1:0]  cpu_wstrb,
    input logic               cpu_ready,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic               rom_sel,
    input logic               ram_sel,
    input logic [NCORE-1:0]   core_sel,
    input logic [STRB_W-1:0]  dev_wstrb,
    input logic               app_mode
);
    logic sw_addr;
    assign sw_addr = (cpu_addr[31:24] == 8'hff) && (cpu_addr[23:2] == 22'h40);

    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel, core_sel}));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> (!rom_sel && !ram_sel && core_sel == '0 &&
                        dev_wstrb == '0 && !cpu_ready));

    // R5
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> app_mode);

    // R5
    mode_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_mode) |-> $past(cpu_valid && (|cpu_wstrb) && sw_addr));

    // R6
    switch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && sw_addr) |-> (cpu_rdata == {DATA_W{app_mode}}));

    // R7
    secret_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (app_mode && cpu_valid && cpu_addr[31:24] == 8'hc2) |->
            (core_sel == '0 && cpu_rdata == '0 && dev_wstrb == '0));
endmodule

bind bus_priv_decoder bpd_chk u_bpd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_addr  (cpu_addr),
    .cpu_wstrb (cpu_wstrb),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .core_sel  (core_sel),
    .dev_wstrb (dev_wstrb),
    .app_mode  (app_mode)
);

// File: tb/test_bus_priv_decoder.sv
module test_bus_priv_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [3:0]   cpu_wstrb = '0;
    logic [31:0]  cpu_wdata = 32'h5a5a_0000;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         rom_sel, ram_sel, app_mode;
    logic [6:0]   core_sel;
    logic [29:0]  mem_addr;
    logic [3:0]   dev_wstrb;
    logic [31:0]  dev_wdata;
    logic [31:0]  rom_rdata = 32'h1111_0000;
    logic [31:0]  ram_rdata = 32'h2222_0000;
    logic [223:0] core_rdata;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    initial for (int i = 0; i < 7; i++) core_rdata[i*32 +: 32] = 32'hc0de_0000 | i;

    bus_priv_decoder i_bus_priv_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_wstrb(cpu_wstrb), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .core_sel(core_sel), .mem_addr(mem_addr), .dev_wstrb(dev_wstrb),
        .dev_wdata(dev_wdata), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
        .core_rdata(core_rdata), .app_mode(app_mode)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [8:0]  sel;    // {rom, ram, core[6:0]}
        logic [31:0] rd;
        logic        wok;    // gated strobe passes
        logic        mode;   // mode after the edge
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0010, 1'b0, 9'h100, 32'h1111_0000, 1'b0, 1'b0}, // R1 rom
        '{32'h4000_0100, 1'b1, 9'h080, 32'h2222_0000, 1'b1, 1'b0}, // R1 ram write
        '{32'h8000_0000, 1'b0, 9'h000, 32'h0000_0000, 1'b0, 1'b0}, // R3
        '{32'hc000_0004, 1'b0, 9'h001, 32'hc0de_0000, 1'b0, 1'b0}, // R2
        '{32'hc100_0000, 1'b0, 9'h002, 32'hc0de_0001, 1'b0, 1'b0}, // R2
        '{32'hc200_0000, 1'b0, 9'h004, 32'hc0de_0002, 1'b0, 1'b0}, // R9 secret boot
        '{32'hc300_0000, 1'b1, 9'h008, 32'hc0de_0003, 1'b1, 1'b0}, // R2
        '{32'hc400_0000, 1'b0, 9'h010, 32'hc0de_0004, 1'b0, 1'b0}, // R2
        '{32'hd000_0010, 1'b1, 9'h020, 32'hc0de_0005, 1'b1, 1'b0}, // R9 scratch write
        '{32'hc500_0000, 1'b0, 9'h000, 32'h0000_0000, 1'b0, 1'b0}, // R2 unknown code
        '{32'hff00_0200, 1'b1, 9'h040, 32'hc0de_0006, 1'b1, 1'b0}, // R9 app-loc write
        '{32'hff00_0300, 1'b0, 9'h040, 32'hc0de_0006, 1'b0, 1'b0}, // R9 auth key read
        '{32'hff00_0100, 1'b0, 9'h000, 32'h0000_0000, 1'b0, 1'b0}, // R6 boot readback
        '{32'hff00_0100, 1'b1, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R5 switch
        '{32'hff00_0100, 1'b0, 9'h000, 32'hffff_ffff, 1'b0, 1'b1}, // R6 app readback
        '{32'hc200_0000, 1'b0, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R7 secret
        '{32'hd000_0010, 1'b1, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R7 scratch write
        '{32'hd000_0010, 1'b0, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R7 scratch read
        '{32'hff00_0304, 1'b0, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R7 auth key
        '{32'hff00_0204, 1'b1, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R8 size write
        '{32'hff00_0204, 1'b0, 9'h040, 32'hc0de_0006, 1'b0, 1'b1}, // R8 size read
        '{32'hff00_0284, 1'b1, 9'h000, 32'h0000_0000, 1'b0, 1'b1}, // R8 identity write
        '{32'hff00_0280, 1'b0, 9'h040, 32'hc0de_0006, 1'b0, 1'b1}, // R8 identity read
        '{32'hc300_0000, 1'b1, 9'h008, 32'hc0de_0003, 1'b1, 1'b1}, // R2 app write
        '{32'h0000_0010, 1'b0, 9'h100, 32'h1111_0000, 1'b0, 1'b1}, // R10 rom in app
        '{32'hff00_0100, 1'b1, 9'h000, 32'hffff_ffff, 1'b0, 1'b1}  // R5 second switch
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        chk("R11 mode after reset", {31'd0, app_mode}, 32'd0);

        // R4: idle request raises nothing
        cpu_addr = 32'hff00_0100; cpu_wstrb = 4'hf;
        #1;
        chk("R4 idle selects", {23'd0, rom_sel, ram_sel, core_sel}, 32'd0);
        chk("R4 idle strobe", {28'd0, dev_wstrb}, 32'd0);
        chk("R4 idle ready", {31'd0, cpu_ready}, 32'd0);
        @(posedge clk); #1;
        chk("R5 idle switch write ignored", {31'd0, app_mode}, 32'd0);

        foreach (TBL[k]) begin
            @(negedge clk);
            cpu_valid = 1'b1;
            cpu_addr  = TBL[k].addr;
            cpu_wstrb = TBL[k].wr ? 4'hb : 4'h0;
            #2;
            chk("R1 R2 R3 R7 R8 R9 select", {23'd0, rom_sel, ram_sel, core_sel},
                {23'd0, TBL[k].sel});
            chk("R10 R6 rdata", cpu_rdata, TBL[k].rd);
            chk("R8 R9 strobe", {28'd0, dev_wstrb},
                {28'd0, TBL[k].wok ? 4'hb : 4'h0});
            chk("R4 ready", {31'd0, cpu_ready}, 32'd1);
            @(posedge clk); #1;
            chk("R5 mode", {31'd0, app_mode}, {31'd0, TBL[k].mode});
        end

        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R1 mem_addr", {2'd0, mem_addr}, 32'h3f00_0100);
        chk("R9 wdata", dev_wdata, 32'h5a5a_0000);

        // R5: only reset returns to boot mode
        repeat (3) @(posedge clk);
        #1;
        chk("R5 still app", {31'd0, app_mode}, 32'd1);
        do_reset();
        #2;
        chk("R11 boot after reset", {31'd0, app_mode}, 32'd0);

        // R5: reading switch does not switch
        cpu_valid = 1'b1; cpu_addr = 32'hff00_0100; cpu_wstrb = 4'h0;
        @(posedge clk); #1;
        chk("R5 read no switch", {31'd0, app_mode}, 32'd0);
        // R5: single-byte strobe write switches
        @(negedge clk);
        cpu_wstrb = 4'h1;
        @(posedge clk); #1;
        chk("R5 byte write switch", {31'd0, app_mode}, 32'd1);
        @(negedge clk);
        cpu_valid = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule